// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block carries 8-bit PCM samples between a parallel side and a frame-based serial PCM bus. Transmit and receive are separate paths. Each path has its own frame sync and its own programmable time-slot number. The serial bit clock and the frame syncs are sampled by a faster system clock, so all of the logic runs in one clock domain. The block detects the rising and falling edges of the bit clock in that domain. It then shifts transmit bits out on the rising edges and samples receive bits on the falling edges.

A mode input selects one of two frame-sync relationships:

- **Immediate mode:** the first bit of the frame goes out on the same bit-clock rising edge at which frame sync is first seen high. This mode has no slot assignment, so slot 0 is always used.
- **Delayed mode:** frame sync is registered first, and slot 0 starts on the next rising edge. A slot counter then locates the assigned transmit and receive slots. A slot number at or beyond the frame length leaves that path idle.

The transmit data goes out on one of two output ports, each with an output enable. Each port also has an active-low enable for an external line driver. That enable is low for the first seven and a half bit times of the slot. Received bytes appear on a parallel output together with a one-cycle valid strobe. A power-down input disables both transmit ports and suppresses reception.

Top module: `pcm_slot_port`

## Requirements
- R1: After reset, dx0_en and dx1_en are low, tsx0_n and tsx1_n are high, and rx_valid is low.
- R2: In immediate mode (delayed_mode=0), the slot number inputs are ignored and slot 0 is used. The transmit bit 7 (MSB) is driven starting at the bit-clock rising edge at which fs_tx is first sampled high. The next seven rising edges each drive the next lower bit.
- R3: In delayed mode (delayed_mode=1), slot 0 begins at the bit-clock rising edge after the one at which frame sync is first sampled high. Slot N begins 8*N bit clocks later. Slot FRAME_SLOTS-1 (31 by default) is still usable.
- R4: In delayed mode, a slot number of FRAME_SLOTS or more assigns no slot. No output enable rises and no rx_valid pulses during that frame.
- R5: The transmit byte is sampled from tx_data at the first bit of the slot. Changes to tx_data later in the slot do not alter the bits sent.
- R6: The line-driver enable of the selected port goes low with the first bit of the slot. It returns high at the bit-clock falling edge inside bit 7, which gives 7.5 bit times. It is high at all other times and is never low while that port's output enable is low.
- R7: The port select chooses the transmit port: tx_port_sel=0 uses dx0, dx0_en and tsx0_n, and tx_port_sel=1 uses dx1, dx1_en and tsx1_n. The other port stays disabled, and the two output enables are never high together.
- R8: Receive bits are sampled MSB first on bit-clock falling edges. They come from dr0 when rx_port_sel=0 and from dr1 when rx_port_sel=1. rx_byte updates, and rx_valid pulses for exactly one clock, in the cycle after the falling edge of bit 7.
- R9: Transmit and receive frames are timed independently, so their frame syncs may be offset by any number of bit clocks.
- R10: While power_down is high, both output enables are low and both driver enables are high from the next clock, and rx_valid stays low.
- R11: A frame sync held high for several bit clocks starts a single frame. Only its first high sample counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk | input | 1 | PCM bit clock, synchronous to clk |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| delayed_mode | input | 1 | 0 = immediate timing, 1 = delayed timing with slot assignment |
| power_down | input | 1 | Disables both transmit ports and reception |
| tx_slot | input | SLOT_W | Assigned transmit slot (delayed mode) |
| rx_slot | input | SLOT_W | Assigned receive slot (delayed mode) |
| tx_port_sel | input | 1 | Transmit port select |
| rx_port_sel | input | 1 | Receive input select |
| tx_data | input | 8 | Byte to transmit, sampled at slot start |
| dr0 | input | 1 | Serial receive input 0 |
| dr1 | input | 1 | Serial receive input 1 |
| dx0 | output | 1 | Serial transmit data, port 0 |
| dx0_en | output | 1 | Output enable for dx0 (low = high impedance) |
| dx1 | output | 1 | Serial transmit data, port 1 |
| dx1_en | output | 1 | Output enable for dx1 (low = high impedance) |
| tsx0_n | output | 1 | Active-low line-driver enable, port 0 |
| tsx1_n | output | 1 | Active-low line-driver enable, port 1 |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |

## Verification
Transmit data, the output enables and the falling edge of the driver enable are registered once. They change at the first clk edge that sees a bit-clock rising edge. The return of the driver enable, the rx_byte update and the rx_valid pulse change at the first clk edge that sees the falling edge inside bit 7. The pulse lasts one clk.

The bench drives each bit-clock edge half a clk period before a sampling edge. It reads the outputs on the next falling clk edge, which is the single cycle in which these results become due. It reads rx_valid one cycle later as well to confirm that the strobe has ended. Every expected window is computed from the frame-sync position, the mode offset and 8 times the slot number.

// File: rtl/pcm_slot_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the timing-mode type for the PCM slot port.
// Assumes: 8-bit slots; the mode encoding is fixed by the delayed_mode pin.
package pcm_slot_pkg;
    localparam int SAMPLE_W  = 8;
    localparam int BIT_IDX_W = $clog2(SAMPLE_W);

    typedef enum logic {
        TIMING_IMMEDIATE = 1'b0,
        TIMING_DELAYED   = 1'b1
    } timing_e;
endpackage

// File: rtl/pcm_bclk_edges.sv
`timescale 1ns/1ps
// Module: detects rising and falling bit-clock edges in the system clock domain.
// Assumes: bclk is synchronous to clk and each of its phases lasts at least
// two clk cycles, so every edge is seen exactly once.
module pcm_bclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    output logic rise,
    output logic fall
);
    logic bclk_q;

    // Keep the previous bit-clock level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk;
    end

    assign rise = bclk & ~bclk_q;
    assign fall = ~bclk & bclk_q;
endmodule

// File: rtl/pcm_frame_timer.sv
`timescale 1ns/1ps
// Module: tracks the bit position within a PCM frame for one direction.
// Frame sync is sampled at bit-clock rising edges; its first high sample
// starts the frame at once (immediate) or one bit later (delayed).
// The counter stops after FRAME_SLOTS*8 bits until the next frame sync.
// Outputs give the position that applies from the current rising edge on.
module pcm_frame_timer
    import pcm_slot_pkg::*;
#(
    parameter int FRAME_SLOTS = 32,
    localparam int FRAME_BITS = FRAME_SLOTS * SAMPLE_W,
    localparam int POS_W      = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             fs,
    input  timing_e          mode,
    output logic             nxt_active,
    output logic [POS_W-1:0] nxt_pos
);
    logic             fs_prev;
    logic             pending;
    logic             active;
    logic [POS_W-1:0] pos;
    logic             pend_n;
    logic             fs_edge;

    assign fs_edge = fs & ~fs_prev;

    // Work out the frame state that takes effect at this rising edge.
    always_comb begin
        nxt_active = active;
        nxt_pos    = pos;
        pend_n     = pending;
        if (rise) begin
            if (mode == TIMING_IMMEDIATE) begin
                pend_n = 1'b0;
                if (fs_edge) begin
                    nxt_active = 1'b1;
                    nxt_pos    = '0;
                end else if (active) begin
                    if (pos == POS_W'(FRAME_BITS - 1)) nxt_active = 1'b0;
                    else                               nxt_pos = pos + 1'b1;
                end
            end else begin
                if (pending) begin
                    nxt_active = 1'b1;
                    nxt_pos    = '0;
                    pend_n     = 1'b0;
                end else begin
                    if (active) begin
                        if (pos == POS_W'(FRAME_BITS - 1)) nxt_active = 1'b0;
                        else                               nxt_pos = pos + 1'b1;
                    end
                    if (fs_edge) pend_n = 1'b1;
                end
            end
        end
    end

    // Commit frame state and the frame-sync history at each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_prev <= 1'b0;
            pending <= 1'b0;
            active  <= 1'b0;
            pos     <= '0;
        end else if (rise) begin
            fs_prev <= fs;
            pending <= pend_n;
            active  <= nxt_active;
            pos     <= nxt_pos;
        end
    end
endmodule

// File: rtl/pcm_slot_select.sv
`timescale 1ns/1ps
// Module: resolves the effective slot number for one direction.
// Immediate mode forces slot 0; delayed mode uses the programmed number and
// flags it unusable when it does not fit in the frame.
module pcm_slot_select
    import pcm_slot_pkg::*;
#(
    parameter int FRAME_SLOTS = 32,
    parameter int SLOT_W      = 6
) (
    input  timing_e           mode,
    input  logic [SLOT_W-1:0] slot_in,
    output logic [SLOT_W-1:0] slot_eff,
    output logic              slot_ok
);
    logic [31:0] slot_wide;

    assign slot_wide = 32'(slot_in);

    // Choose slot 0 or the programmed slot and check it against the frame length.
    always_comb begin
        if (mode == TIMING_DELAYED) begin
            slot_eff = slot_in;
            slot_ok  = slot_wide < 32'(FRAME_SLOTS);
        end else begin
            slot_eff = '0;
            slot_ok  = 1'b1;
        end
    end
endmodule

// File: rtl/pcm_tx_engine.sv
`timescale 1ns/1ps
// Module: transmit shifter for the assigned slot.
// Loads the byte at the first bit of the slot, sends MSB first on rising
// edges, and drives the line-driver enable low from bit 0 until the falling
// edge inside bit 7. A slot is only entered from its first bit.
module pcm_tx_engine
    import pcm_slot_pkg::*;
#(
    parameter int POS_W  = 8,
    parameter int SLOT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                fall,
    input  logic                power_down,
    input  logic                nxt_active,
    input  logic [POS_W-1:0]    nxt_pos,
    input  logic                slot_ok,
    input  logic [SLOT_W-1:0]   slot_num,
    input  logic                port_sel,
    input  logic [SAMPLE_W-1:0] tx_data,
    output logic                dx_bit,
    output logic                dx_oe,
    output logic                drv_n,
    output logic                sel_q
);
    logic [SLOT_W-1:0]    nxt_slot;
    logic [BIT_IDX_W-1:0] nxt_bit;
    logic                 hit;
    logic                 first;
    logic                 live;
    logic                 take;
    logic [BIT_IDX_W-1:0] bit_q;
    logic [SAMPLE_W-1:0]  shreg;

    assign nxt_slot = SLOT_W'(nxt_pos[POS_W-1:BIT_IDX_W]);
    assign nxt_bit  = nxt_pos[BIT_IDX_W-1:0];
    assign hit      = nxt_active && slot_ok && (nxt_slot == slot_num);
    assign first    = hit && (nxt_bit == '0);
    assign take     = hit && (first || live);

    // Advance the shifter and the enables at bit-clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live   <= 1'b0;
            dx_oe  <= 1'b0;
            drv_n  <= 1'b1;
            dx_bit <= 1'b0;
            bit_q  <= '0;
            shreg  <= '0;
            sel_q  <= 1'b0;
        end else if (power_down) begin
            live  <= 1'b0;
            dx_oe <= 1'b0;
            drv_n <= 1'b1;
        end else if (rise) begin
            live  <= take;
            dx_oe <= take;
            drv_n <= ~take;
            bit_q <= nxt_bit;
            if (take && first) begin
                dx_bit <= tx_data[SAMPLE_W-1];
                shreg  <= {tx_data[SAMPLE_W-2:0], 1'b0};
                sel_q  <= port_sel;
            end else if (take) begin
                dx_bit <= shreg[SAMPLE_W-1];
                shreg  <= {shreg[SAMPLE_W-2:0], 1'b0};
            end
        end else if (fall && live && (bit_q == BIT_IDX_W'(SAMPLE_W - 1))) begin
            drv_n <= 1'b1;
        end
    end
endmodule

// File: rtl/pcm_rx_engine.sv
`timescale 1ns/1ps
// Module: receive shifter for the assigned slot.
// Arms at the rising edge that opens each bit of the slot, samples the
// selected input at the following falling edge, MSB first, and strobes the
// byte for one clk after bit 7. A slot is only entered from its first bit.
module pcm_rx_engine
    import pcm_slot_pkg::*;
#(
    parameter int POS_W  = 8,
    parameter int SLOT_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                fall,
    input  logic                power_down,
    input  logic                nxt_active,
    input  logic [POS_W-1:0]    nxt_pos,
    input  logic                slot_ok,
    input  logic [SLOT_W-1:0]   slot_num,
    input  logic                port_sel,
    input  logic                dr0,
    input  logic                dr1,
    output logic [SAMPLE_W-1:0] rx_byte,
    output logic                rx_valid
);
    logic [SLOT_W-1:0]    nxt_slot;
    logic [BIT_IDX_W-1:0] nxt_bit;
    logic                 hit;
    logic                 take;
    logic                 live;
    logic [BIT_IDX_W-1:0] bit_q;
    logic [SAMPLE_W-1:0]  shreg;
    logic                 din;

    assign nxt_slot = SLOT_W'(nxt_pos[POS_W-1:BIT_IDX_W]);
    assign nxt_bit  = nxt_pos[BIT_IDX_W-1:0];
    assign hit      = nxt_active && slot_ok && (nxt_slot == slot_num);
    assign take     = hit && ((nxt_bit == '0) || live);
    assign din      = port_sel ? dr1 : dr0;

    // Arm on rising edges, sample on falling edges, strobe after bit 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live     <= 1'b0;
            bit_q    <= '0;
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (power_down) begin
                live <= 1'b0;
            end else if (rise) begin
                live  <= take;
                bit_q <= nxt_bit;
            end else if (fall && live) begin
                shreg <= {shreg[SAMPLE_W-2:0], din};
                if (bit_q == BIT_IDX_W'(SAMPLE_W - 1)) begin
                    rx_byte  <= {shreg[SAMPLE_W-2:0], din};
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_slot_port.sv
`timescale 1ns/1ps
// Module: top of the PCM time-slot serial interface.
// Two independent frame timers (transmit, receive) feed a transmit and a
// receive engine; the transmit result is steered to one of two ports.
// Assumes: bclk and frame syncs are synchronous to clk, bclk phases last at
// least two clk cycles, and pads apply the output enables as tri-state.
module pcm_slot_port
    import pcm_slot_pkg::*;
#(
    parameter int FRAME_SLOTS = 32,
    parameter int SLOT_W      = 6,
    localparam int POS_W      = $clog2(FRAME_SLOTS * SAMPLE_W),
    localparam int N_PORTS    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk,
    input  logic                fs_tx,
    input  logic                fs_rx,
    input  logic                delayed_mode,
    input  logic                power_down,
    input  logic [SLOT_W-1:0]   tx_slot,
    input  logic [SLOT_W-1:0]   rx_slot,
    input  logic                tx_port_sel,
    input  logic                rx_port_sel,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                dr0,
    input  logic                dr1,
    output logic                dx0,
    output logic                dx0_en,
    output logic                dx1,
    output logic                dx1_en,
    output logic                tsx0_n,
    output logic                tsx1_n,
    output logic [SAMPLE_W-1:0] rx_byte,
    output logic                rx_valid
);
    timing_e            mode;
    logic               rise, fall;
    logic               tx_nact, rx_nact;
    logic [POS_W-1:0]   tx_npos, rx_npos;
    logic [SLOT_W-1:0]  tx_eff, rx_eff;
    logic               tx_ok, rx_ok;
    logic               tx_bit, tx_oe, tx_drv_n, tx_sel_q;
    logic [N_PORTS-1:0] dx_v, en_v, drv_v;

    assign mode = timing_e'(delayed_mode);

    pcm_bclk_edges u_edges (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .rise(rise), .fall(fall)
    );

    pcm_frame_timer #(.FRAME_SLOTS(FRAME_SLOTS)) u_tx_timer (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fs(fs_tx), .mode(mode),
        .nxt_active(tx_nact), .nxt_pos(tx_npos)
    );

    pcm_frame_timer #(.FRAME_SLOTS(FRAME_SLOTS)) u_rx_timer (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fs(fs_rx), .mode(mode),
        .nxt_active(rx_nact), .nxt_pos(rx_npos)
    );

    pcm_slot_select #(.FRAME_SLOTS(FRAME_SLOTS), .SLOT_W(SLOT_W)) u_tx_sel (
        .mode(mode), .slot_in(tx_slot), .slot_eff(tx_eff), .slot_ok(tx_ok)
    );

    pcm_slot_select #(.FRAME_SLOTS(FRAME_SLOTS), .SLOT_W(SLOT_W)) u_rx_sel (
        .mode(mode), .slot_in(rx_slot), .slot_eff(rx_eff), .slot_ok(rx_ok)
    );

    pcm_tx_engine #(.POS_W(POS_W), .SLOT_W(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .power_down(power_down), .nxt_active(tx_nact), .nxt_pos(tx_npos),
        .slot_ok(tx_ok), .slot_num(tx_eff), .port_sel(tx_port_sel),
        .tx_data(tx_data), .dx_bit(tx_bit), .dx_oe(tx_oe),
        .drv_n(tx_drv_n), .sel_q(tx_sel_q)
    );

    pcm_rx_engine #(.POS_W(POS_W), .SLOT_W(SLOT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
        .power_down(power_down), .nxt_active(rx_nact), .nxt_pos(rx_npos),
        .slot_ok(rx_ok), .slot_num(rx_eff), .port_sel(rx_port_sel),
        .dr0(dr0), .dr1(dr1), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    // Steer the transmit engine to the latched port; the other stays off.
    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign dx_v[p]  = tx_bit;
        assign en_v[p]  = tx_oe && (tx_sel_q == 1'(p));
        assign drv_v[p] = tx_drv_n || (tx_sel_q != 1'(p));
    end

    assign dx0    = dx_v[0];
    assign dx1    = dx_v[1];
    assign dx0_en = en_v[0];
    assign dx1_en = en_v[1];
    assign tsx0_n = drv_v[0];
    assign tsx1_n = drv_v[1];
endmodule

// File: rtl/pcm_slot_port_chk.sv
`timescale 1ns/1ps
// Module: property checker for pcm_slot_port, attached with bind below.
module pcm_slot_port_chk (
    input logic clk,
    input logic rst_n,
    input logic power_down,
    input logic dx0_en,
    input logic dx1_en,
    input logic tsx0_n,
    input logic tsx1_n,
    input logic rx_valid
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dx0_en && !dx1_en && tsx0_n && tsx1_n && !rx_valid));

    a_r7_one_port_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !(dx0_en && dx1_en));

    a_r6_drv0_inside_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !tsx0_n |-> dx0_en);

    a_r6_drv1_inside_slot: assert property (@(posedge clk) disable iff (!rst_n)
        !tsx1_n |-> dx1_en);

    a_r6_drv0_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dx0_en) |-> !tsx0_n);

    a_r6_drv1_low_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dx1_en) |-> !tsx1_n);

    a_r10_pd_ports_off: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (!dx0_en && !dx1_en && tsx0_n && tsx1_n));

    a_r10_pd_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> !rx_valid);

    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .power_down(power_down),
    .dx0_en(dx0_en), .dx1_en(dx1_en), .tsx0_n(tsx0_n), .tsx1_n(tsx1_n),
    .rx_valid(rx_valid)
);

// File: tb/pcm_slot_port_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, for pcm_slot_port.
// Each bit clock spans 8 clk; inputs change on falling clk edges.
module pcm_slot_port_bench;
    localparam int FRAME_SLOTS = 32;
    localparam int SLOT_W      = 6;

    logic       clk = 1'b0;
    logic       rst_n, bclk, fs_tx, fs_rx, delayed_mode, power_down;
    logic [5:0] tx_slot, rx_slot;
    logic       tx_port_sel, rx_port_sel, dr0, dr1;
    logic [7:0] tx_data;
    logic       dx0, dx0_en, dx1, dx1_en, tsx0_n, tsx1_n, rx_valid;
    logic [7:0] rx_byte;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    pcm_slot_port #(.FRAME_SLOTS(FRAME_SLOTS), .SLOT_W(SLOT_W)) u_pcm_slot_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .delayed_mode(delayed_mode), .power_down(power_down),
        .tx_slot(tx_slot), .rx_slot(rx_slot), .tx_port_sel(tx_port_sel),
        .rx_port_sel(rx_port_sel), .tx_data(tx_data), .dr0(dr0), .dr1(dr1),
        .dx0(dx0), .dx0_en(dx0_en), .dx1(dx1), .dx1_en(dx1_en),
        .tsx0_n(tsx0_n), .tsx1_n(tsx1_n), .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; bclk = 1'b0; fs_tx = 1'b0; fs_rx = 1'b0;
        delayed_mode = 1'b0; power_down = 1'b0; tx_slot = '0; rx_slot = '0;
        tx_port_sel = 1'b0; rx_port_sel = 1'b0; dr0 = 1'b1; dr1 = 1'b1;
        tx_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One bit clock: rise, sample, fall, sample twice.
    task automatic bit_cycle(input logic ftx, input logic frx, input logic d0,
                             input logic d1, output logic [3:0] en_drv,
                             output logic [1:0] dxs, output logic [1:0] drv_f,
                             output logic v1, output logic v2,
                             output logic [7:0] rb);
        @(negedge clk);
        bclk = 1'b1; fs_tx = ftx; fs_rx = frx; dr0 = d0; dr1 = d1;
        @(negedge clk);
        en_drv = {dx0_en, dx1_en, tsx0_n, tsx1_n};
        dxs    = {dx0, dx1};
        repeat (2) @(negedge clk);
        @(negedge clk);
        bclk = 1'b0;
        @(negedge clk);
        drv_f = {tsx0_n, tsx1_n};
        v1    = rx_valid;
        rb    = rx_byte;
        @(negedge clk);
        v2 = rx_valid;
        @(negedge clk);
    endtask

    task automatic run_frame(input string tag, input logic mode, input logic pd,
                             input int tslot, input logic tsel, input int rslot,
                             input logic rsel, input logic [7:0] tb,
                             input logic [7:0] rbv, input int ftx_at,
                             input int ftx_len, input int frx_at,
                             input int frx_len, input int ncyc);
        int  d, ts, rs;
        bit  tx_ok, rx_ok;
        apply_reset();
        delayed_mode = mode; power_down = pd;
        tx_slot = 6'(tslot); rx_slot = 6'(rslot);
        tx_port_sel = tsel; rx_port_sel = rsel;
        d     = mode ? 1 : 0;
        ts    = ftx_at + d + 8 * (mode ? tslot : 0);
        rs    = frx_at + d + 8 * (mode ? rslot : 0);
        tx_ok = !pd && (!mode || tslot < FRAME_SLOTS);
        rx_ok = !pd && (!mode || rslot < FRAME_SLOTS);
        for (int c = 0; c < ncyc; c++) begin
            logic       ftx, frx, in_tx, in_rx, rbit, v1, v2;
            logic [3:0] en_drv, exp_ed;
            logic [1:0] dxs, drv_f, exp_f;
            logic [7:0] rb;
            ftx   = (c >= ftx_at) && (c < ftx_at + ftx_len);
            frx   = (c >= frx_at) && (c < frx_at + frx_len);
            in_tx = tx_ok && (c >= ts) && (c < ts + 8);
            in_rx = rx_ok && (c >= rs) && (c < rs + 8);
            tx_data = (tx_ok && c > ts) ? ~tb : tb;  // R5: late change must not matter
            rbit  = in_rx ? rbv[7 - (c - rs)] : 1'b1;
            bit_cycle(ftx, frx, rsel ? ~rbit : rbit, rsel ? rbit : ~rbit,
                      en_drv, dxs, drv_f, v1, v2, rb);
            exp_ed = {in_tx && !tsel, in_tx && tsel, !(in_tx && !tsel), !(in_tx && tsel)};
            check(tag, $sformatf("cycle %0d enables/drivers after rise", c),
                  32'(en_drv), 32'(exp_ed));
            if (in_tx)
                check(tag, $sformatf("cycle %0d data bit", c),
                      32'(tsel ? dxs[0] : dxs[1]), 32'(tb[7 - (c - ts)]));
            exp_f = {!(in_tx && !tsel && c < ts + 7), !(in_tx && tsel && c < ts + 7)};
            check(tag, $sformatf("cycle %0d drivers after fall", c),
                  32'(drv_f), 32'(exp_f));
            check(tag, $sformatf("cycle %0d rx_valid", c),
                  32'(v1), 32'(rx_ok && c == rs + 7));
            if (rx_ok && c == rs + 7) begin
                check(tag, "rx_byte", 32'(rb), 32'(rbv));
                check(tag, "rx_valid one cycle", 32'(v2), 32'd0);
            end
        end
    endtask

    task automatic t_reset();
        apply_reset();
        check("R1", "dx0_en", 32'(dx0_en), 32'd0);
        check("R1", "dx1_en", 32'(dx1_en), 32'd0);
        check("R1", "tsx0_n", 32'(tsx0_n), 32'd1);
        check("R1", "tsx1_n", 32'(tsx1_n), 32'd1);
        check("R1", "rx_valid", 32'(rx_valid), 32'd0);
    endtask

    // Immediate mode: slot inputs ignored, port 0 both ways.
    task automatic t_immediate();
        run_frame("R2/R5/R6/R8", 1'b0, 1'b0, 9, 1'b0, 9, 1'b0, 8'hA5, 8'h3C,
                  2, 1, 2, 1, 14);
    endtask

    // Delayed mode, port 1, skewed syncs, wide transmit sync.
    task automatic t_delayed_skew();
        run_frame("R3/R7/R9/R11", 1'b1, 1'b0, 3, 1'b1, 2, 1'b1, 8'h6B, 8'hD2,
                  2, 3, 7, 1, 40);
    endtask

    // Last slot of the frame on both paths.
    task automatic t_last_slot();
        run_frame("R3", 1'b1, 1'b0, FRAME_SLOTS - 1, 1'b0, FRAME_SLOTS - 1, 1'b1,
                  8'h81, 8'h7E, 2, 1, 2, 1, 262);
    endtask

    // Slot numbers outside the frame assign nothing.
    task automatic t_beyond_frame();
        run_frame("R4", 1'b1, 1'b0, FRAME_SLOTS, 1'b0, 40, 1'b0, 8'hFF, 8'h55,
                  2, 1, 2, 1, 266);
    endtask

    // Power-down keeps both ports off and suppresses reception.
    task automatic t_power_down();
        run_frame("R10", 1'b1, 1'b1, 1, 1'b1, 1, 1'b0, 8'hC3, 8'h99,
                  2, 1, 2, 1, 24);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_immediate();
        t_delayed_skew();
        t_last_slot();
        t_beyond_frame();
        t_power_down();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule